// File: doc/BRIEF.md
# Two-Wire Register-File Target

This block lets a bus master on a two-wire serial bus (SCL, SDA) read and write a 256-byte register array. SCL is only an input and is never held low. SDA is driven open-drain: the block only ever pulls it low, through an output-enable. Both bus lines are oversampled by the system clock. The START and STOP conditions, the bit edges, the address match, the acknowledge handling and the pointer logic all run in that clock domain.

A transfer opens with START and an address byte. The upper seven bits of that byte must equal the device address, 0x56. Its bit 0 chooses the direction, where 1 means read. In a write, the first data byte sets a byte pointer, and each later byte is stored at that pointer, which then steps forward. A read returns bytes from the same pointer, which also steps forward after each byte. The pointer is kept across STOP and repeated START, so the master can set it with a short write and then read from there after a repeated START. When the master answers a byte with NACK, the block goes idle until the next START.

Top module: `i2c_regfile_target`

## Requirements
- R1: Out of reset, sda_oe_o is 0, the pointer is 0, and register byte n holds (n+1) mod 256.
- R2: The address byte 0xAC (write) or 0xAD (read) is acknowledged: sda_oe_o is 1 during the ninth SCL high phase. Bit 0 of the address byte selects read when it is 1.
- R3: An address byte whose upper seven bits differ from 0x56 is not acknowledged. The block then leaves SDA released and ignores all traffic, with no change to the registers or the pointer, until the next START.
- R4: In a write, the first byte after the address is acknowledged and loaded into the pointer. It is not stored in the register array.
- R5: In a write, every later byte is acknowledged and stored at the pointer, and the pointer then increments.
- R6: In a read, the byte at the pointer is shifted out MSB first, starting right after the address acknowledge, and the pointer increments for each byte loaded.
- R7: During a read, SDA is released for the acknowledge bit. An ACK (low) from the master makes the block send the next byte. A NACK (high) makes it idle with SDA released until the next START.
- R8: The pointer wraps from 255 to 0, for both writes and reads.
- R9: The pointer keeps its value across STOP and across a repeated START.
- R10: A STOP (SDA rising while SCL is high) makes the block idle at any point, so bytes clocked afterwards without a START are not acknowledged.
- R11: A START (SDA falling while SCL is high) restarts address reception at any point, even in the middle of a byte. Shifting begins only once SCL is low after the START.
- R12: sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Most internal faults appear at the bus within one byte. A wrong pointer or a memory write that was lost or misplaced shows as a wrong data byte on the next read of that location. An address decode fault or a state machine stuck after NACK or STOP shows as an acknowledge bit that appears or disappears at the ninth clock of that same byte. A shift or bit-count slip corrupts the very next byte sent, and any change to the SDA enable while SCL is high is caught by a monitor in the cycle it happens.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,     // START seen, waiting for SCL low
    ST_RX,       // shifting in a byte
    ST_ACK_OUT,  // driving ACK
    ST_TX,       // shifting out a byte
    ST_ACK_IN,   // sampling master ACK
    ST_TX_NEXT   // ACK seen, load on next SCL fall
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_WR,
    PH_RD
  } ph_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic q_prev_o
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '1;
    else         chain <= {chain[STAGES-1:0], d_i};
  end

  assign q_o      = chain[STAGES-1];
  assign q_prev_o = chain[STAGES];

endmodule

// File: rtl/i2c_tgt_mem.sv
module i2c_tgt_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i + 1);
    end else if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h56,
  parameter int         PTR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_hi_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             we_o,
  output logic [7:0]       wdata_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             sda_oe_o,
  output st_e              st_o,
  output ph_e              ph_o
);

  localparam int BW = 8;
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0]    LAST  = CW'(BW - 1);
  localparam logic [PTR_W-1:0] P_ONE = 1;

  st_e              st;
  ph_e              ph;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    sh;
  logic             full;
  logic [PTR_W-1:0] ptr;
  logic             oe;
  logic             byte_end;

  assign byte_end = (st == ST_RX) && scl_fall_i && full;
  assign we_o     = byte_end && (ph == PH_WR) && !start_i && !stop_i;
  assign wdata_o  = sh;
  assign ptr_o    = ptr;
  assign sda_oe_o = oe;
  assign st_o     = st;
  assign ph_o     = ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= ST_IDLE;
      ph   <= PH_ADDR;
      cnt  <= '0;
      sh   <= '0;
      full <= 1'b0;
      ptr  <= '0;
      oe   <= 1'b0;
    end else if (start_i) begin
      st   <= ST_WAIT;
      ph   <= PH_ADDR;
      cnt  <= '0;
      full <= 1'b0;
      oe   <= 1'b0;
    end else if (stop_i) begin
      st   <= ST_IDLE;
      full <= 1'b0;
      oe   <= 1'b0;
    end else begin
      case (st)
        ST_WAIT: if (!scl_hi_i) begin
          st  <= ST_RX;
          cnt <= '0;
        end
        ST_RX: begin
          if (scl_rise_i) begin
            sh   <= {sh[BW-2:0], sda_i};
            cnt  <= cnt + 1'b1;
            full <= (cnt == LAST);
          end else if (byte_end) begin
            full <= 1'b0;
            case (ph)
              PH_ADDR: begin
                if (sh[BW-1:1] == DEV_ADDR) begin
                  oe <= 1'b1;
                  st <= ST_ACK_OUT;
                  ph <= sh[0] ? PH_RD : PH_PTR;
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_PTR: begin
                ptr <= PTR_W'(sh);
                ph  <= PH_WR;
                oe  <= 1'b1;
                st  <= ST_ACK_OUT;
              end
              PH_WR: begin
                ptr <= ptr + P_ONE;
                oe  <= 1'b1;
                st  <= ST_ACK_OUT;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
        ST_ACK_OUT: if (scl_fall_i) begin
          cnt <= '0;
          if (ph == PH_RD) begin
            sh  <= rd_data_i;
            oe  <= ~rd_data_i[BW-1];
            ptr <= ptr + P_ONE;
            st  <= ST_TX;
          end else begin
            oe <= 1'b0;
            st <= ST_RX;
          end
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt == LAST) begin
            oe <= 1'b0;
            st <= ST_ACK_IN;
          end else begin
            sh  <= {sh[BW-2:0], 1'b0};
            oe  <= ~sh[BW-2];
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACK_IN: if (scl_rise_i) st <= sda_i ? ST_IDLE : ST_TX_NEXT;
        ST_TX_NEXT: if (scl_fall_i) begin
          sh  <= rd_data_i;
          oe  <= ~rd_data_i[BW-1];
          ptr <= ptr + P_ONE;
          cnt <= '0;
          st  <= ST_TX;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h56,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int DW = 8;

  logic             scl_q, scl_p, sda_q, sda_p;
  logic             scl_rise, scl_fall, start, stop;
  logic             we;
  logic [DW-1:0]    wdata, rd_data;
  logic [PTR_W-1:0] ptr;
  st_e              st;
  ph_e              ph;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_q), .q_prev_o(scl_p)
  );

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_q), .q_prev_o(sda_p)
  );

  assign scl_rise = scl_q & ~scl_p;
  assign scl_fall = ~scl_q & scl_p;
  assign start    = scl_q & scl_p & sda_p & ~sda_q;
  assign stop     = scl_q & scl_p & ~sda_p & sda_q;

  i2c_tgt_engine #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_hi_i  (scl_q),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_q),
    .start_i   (start),
    .stop_i    (stop),
    .rd_data_i (rd_data),
    .we_o      (we),
    .wdata_o   (wdata),
    .ptr_o     (ptr),
    .sda_oe_o  (sda_oe_o),
    .st_o      (st),
    .ph_o      (ph)
  );

  i2c_tgt_mem #(.AW(PTR_W), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .addr_i (ptr),
    .wdata_i(wdata),
    .rdata_o(rd_data)
  );

endmodule

// File: rtl/i2c_regfile_target_chk.sv
module i2c_regfile_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_q_i,
  input logic             scl_p_i,
  input logic             start_i,
  input logic             stop_i,
  input st_e              st_i,
  input ph_e              ph_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic             sda_oe_i
);

  localparam logic [PTR_W-1:0] ONE = 1;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_IDLE |-> !sda_oe_i); // R3

  AST_ACK_IN_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_ACK_IN |-> !sda_oe_i); // R7

  AST_START_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_i == ST_WAIT) && (ph_i == PH_ADDR)); // R11

  AST_WAIT_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_WAIT) && scl_q_i && !stop_i |=> st_i == ST_WAIT); // R11

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> st_i == ST_IDLE); // R10

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i != $past(ptr_i)) && ($past(ph_i) != PH_PTR) |-> ptr_i == $past(ptr_i) + ONE); // R8

  AST_SDA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_q_i && scl_p_i && !start_i && !stop_i |=> $stable(sda_oe_i)); // R12

endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_q_i (scl_q),
  .scl_p_i (scl_p),
  .start_i (start),
  .stop_i  (stop),
  .st_i    (st),
  .ph_i    (ph),
  .ptr_i   (ptr),
  .sda_oe_i(sda_oe_o)
);

// File: tb/tb_i2c_regfile_target.sv
module tb_i2c_regfile_target;

  localparam int H = 10;  // half SCL period in clk cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_low = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = ~(sda_low | sda_oe);

  always #10 clk = ~clk;

  i2c_regfile_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int checks = 0;
  int errors = 0;
  int hold_viol = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  logic scl_d = 1'b1;
  logic oe_d = 1'b0;

  // R12 monitor: enable must not move while SCL stays high
  always @(negedge clk) begin
    if (rst_n && scl && scl_d && (sda_oe !== oe_d)) hold_viol++;
    scl_d <= scl;
    oe_d  <= sda_oe;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    if (!scl) begin
      sda_low = 1'b0; tick(H/2);
      scl = 1'b1;     tick(H);
    end
    sda_low = 1'b1; tick(H);
    scl = 1'b0;     tick(H/2);
  endtask

  task automatic i2c_stop();
    sda_low = 1'b1; tick(H/2);
    scl = 1'b1;     tick(H);
    sda_low = 1'b0; tick(H);
  endtask

  task automatic bit_w(logic b);
    sda_low = ~b; tick(H/2);
    scl = 1'b1;   tick(H);
    scl = 1'b0;   tick(H/2);
  endtask

  task automatic bit_r(output logic b);
    sda_low = 1'b0; tick(H/2);
    scl = 1'b1;     tick(H/2);
    b = sda_line;   tick(H/2);
    scl = 1'b0;     tick(H/2);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    bit_r(a);
    acked = !a;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit ack_m);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      bit_r(v);
      b[i] = v;
    end
    bit_w(!ack_m);
  endtask

  task automatic wr_xfer(logic [7:0] p, int n);
    bit a;
    logic [7:0] d;
    i2c_start();
    send_byte(8'hAC, a); chk(a, "R2 write address ack", a, 1);
    send_byte(p, a);     chk(a, "R4 pointer byte ack", a, 1);
    ref_ptr = p;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, a); chk(a, "R5 data byte ack", a, 1);
      ref_mem[ref_ptr] = d;
      ref_ptr = ref_ptr + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic rd_bytes(int n, string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i < n - 1);
      chk(d === ref_mem[ref_ptr], tag, d, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
  endtask

  task automatic rd_xfer(int n, string tag);
    bit a;
    i2c_start();
    send_byte(8'hAD, a); chk(a, "R2 read address ack", a, 1);
    rd_bytes(n, tag);
    i2c_stop();
  endtask

  task automatic set_ptr_rd(logic [7:0] p, int n, string tag);
    bit a;
    i2c_start();
    send_byte(8'hAC, a); chk(a, "R2 write address ack", a, 1);
    send_byte(p, a);     chk(a, "R4 pointer byte ack", a, 1);
    ref_ptr = p;
    i2c_start();
    send_byte(8'hAD, a); chk(a, "R9 read ack after repeated start", a, 1);
    rd_bytes(n, tag);
    i2c_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'(i + 1);
    ref_ptr = 8'd0;

    tick(5);
    chk(sda_oe === 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_oe === 1'b0, "R1 idle after reset", sda_oe, 0);

    // R1 R6: reset pattern read from pointer 0
    rd_xfer(4, "R1 R6 reset pattern read");

    // R4 R5: set pointer 0x10, write three bytes
    wr_xfer(8'h10, 3);
    set_ptr_rd(8'h04, 1, "R4 pointer byte not stored");
    set_ptr_rd(8'h10, 3, "R9 R5 readback after repeated start");

    // R3: wrong write address, following bytes ignored
    i2c_start();
    send_byte(8'hAE, a); chk(!a, "R3 no ack wrong address", a, 0);
    send_byte(8'h20, a); chk(!a, "R3 no ack after mismatch", a, 0);
    send_byte(8'h99, a); chk(!a, "R3 no ack after mismatch", a, 0);
    i2c_stop();
    // R3: wrong read address, nothing driven
    i2c_start();
    send_byte(8'hAF, a); chk(!a, "R3 no ack wrong read address", a, 0);
    recv_byte(d, 1'b0);  chk(d === 8'hFF, "R3 bus released", d, 8'hFF);
    i2c_stop();
    rd_xfer(1, "R3 pointer and memory untouched");

    // R7: master NACK ends the read
    i2c_start();
    send_byte(8'hAD, a); chk(a, "R2 read address ack", a, 1);
    rd_bytes(2, "R7 read before NACK");
    recv_byte(d, 1'b1);  chk(d === 8'hFF, "R7 released after NACK", d, 8'hFF);
    i2c_stop();
    rd_xfer(1, "R7 pointer after NACK");

    // R8: wrap
    wr_xfer(8'hFE, 3);
    set_ptr_rd(8'hFE, 3, "R8 wrap readback");
    rd_xfer(1, "R8 pointer after wrap");

    // R10: STOP ends transfer
    i2c_start();
    send_byte(8'hAC, a); chk(a, "R2 write address ack", a, 1);
    send_byte(8'h40, a); chk(a, "R4 pointer byte ack", a, 1);
    ref_ptr = 8'h40;
    i2c_stop();
    send_byte(8'h55, a); chk(!a, "R10 no ack after STOP", a, 0);
    i2c_stop();
    rd_xfer(2, "R10 data after STOP");

    // R11: START in the middle of a byte
    i2c_start();
    bit_w(1'b1); bit_w(1'b0); bit_w(1'b1);
    i2c_start();
    send_byte(8'hAD, a); chk(a, "R11 ack after mid-byte START", a, 1);
    rd_bytes(1, "R11 read after mid-byte START");
    i2c_stop();

    // constrained random traffic
    for (int it = 0; it < 24; it++) begin
      logic [7:0] p;
      int n;
      p = 8'($urandom);
      n = 1 + int'($urandom % 4);
      case ($urandom % 3)
        0: wr_xfer(p, n);
        1: set_ptr_rd(p, n, "R9 R6 random read");
        default: rd_xfer(n, "R6 R5 random continue read");
      endcase
    end

    chk(hold_viol == 0, "R12 enable stable while SCL high", hold_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL all requirements (watchdog): actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule